// File: doc/BRIEF.md
# USB Host Transaction Error Tracker

This block follows the outcome of every bus transaction issued on behalf of one queue-head style endpoint of a USB host controller. Each cycle it may receive one transaction result. The result carries an outcome code, the token kind, the device speed class, the handshake that came back, and a flag marking the complete-split phase. From these the block decides whether the transaction succeeded, counts as a retryable error, or was babble.

Retryable errors set a sticky transaction-error flag and step a 2-bit retry counter down by one. When the counter runs out (it moves from one to zero), the block raises an error interrupt status bit and halts the endpoint. Babble halts the endpoint at once and sets its own flag. While halted, the block ignores all results until software issues a clear-halt strobe. That strobe reloads the counter from a software value and clears both flags. Software acknowledges the interrupt by writing a one to the status bit.

The control is a three-state machine:
- `ST_ACTIVE`: the endpoint runs.
- `ST_HALT_ERR`: halted because the retry counter ran out.
- `ST_HALT_BABBLE`: halted because of babble.

Its transitions are:
- `ACTIVE->HALT_ERR` on a counted error while the counter is one.
- `ACTIVE->HALT_BABBLE` on an overrun result.
- `HALT_*->ACTIVE` on clear-halt.
- `ACTIVE->ACTIVE` in every other case.

Top module: `xact_err_tracker`

## Requirements
- R1: With `res_vld` high and the endpoint not halted, the outcome codes 1 (CRC), 2 (timeout), 3 (unrecognised PID) and 5 (protocol error) set `xact_err` and decrement a nonzero `err_cnt` by one. The result is visible one clock later.
- R2: `err_irq` rises only on the edge where `err_cnt` goes from 1 to 0, and `halted` rises on that same edge.
- R3: Outcome code 0 with `pid_kind`=2 (SETUP), `hs_dev`=1 and `hshake`=1 (NAK) counts as a protocol error with the effects of R1. With `hshake`=0 (ACK) it counts as a success.
- R4: Outcome code 0 with `pid_kind`=2 (SETUP), `hs_dev`=1 and `hshake`=2 (NYET) counts as a protocol error with the effects of R1.
- R5: Outcome code 0 with `hs_dev`=0, `csplit`=1 and `hshake`=1 (NAK) counts as a protocol error. The same NAK with `csplit`=0 counts as a success.
- R6: Outcome code 4 (overrun) sets `babble` and `halted` one clock later. It leaves `err_cnt` unchanged and does not raise `err_irq`.
- R7: A status write (`sts_wr`=1) with `sts_wdata`=1 clears `err_irq`. With `sts_wdata`=0 the write leaves `err_irq` unchanged.
- R8: When `err_cnt` is 0, counted errors still set `xact_err`, but `err_cnt` stays 0 and neither `err_irq` nor `halted` is raised.
- R9: While halted, results change neither `err_cnt` nor the flags. A `clr_halt` pulse loads `err_cnt` from `cnt_init`, clears `halted`, `xact_err` and `babble`, and takes priority over a result presented in the same cycle.
- R10: A success (code 0 without reclassification, or the unused codes 6 and 7) leaves `err_cnt` unchanged and does not clear `xact_err`.
- R11: If an interrupt event and a clearing status write arrive in the same cycle, `err_irq` is set afterwards.
- R12: After reset the outputs are as follows: `err_cnt`=0, `xact_err`=0, `babble`=0, `halted`=0 and `err_irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_vld | input | 1 | A transaction result is present this cycle |
| res_code | input | 3 | Outcome: 0 ok, 1 CRC, 2 timeout, 3 bad PID, 4 overrun, 5 protocol |
| pid_kind | input | 2 | Token: 0 OUT, 1 IN, 2 SETUP |
| hs_dev | input | 1 | Device is high-speed |
| hshake | input | 2 | Handshake: 0 ACK, 1 NAK, 2 NYET, 3 STALL |
| csplit | input | 1 | Result belongs to a complete-split phase |
| clr_halt | input | 1 | Software strobe: resume endpoint and reload counter |
| cnt_init | input | CNT_W | Value loaded into the retry counter on `clr_halt` |
| sts_wr | input | 1 | Software write to the interrupt status bit |
| sts_wdata | input | 1 | Write data; 1 clears the status bit |
| err_cnt | output | CNT_W | Retry counter |
| xact_err | output | 1 | Sticky transaction-error flag |
| babble | output | 1 | Babble flag |
| halted | output | 1 | Endpoint halted |
| err_irq | output | 1 | Error interrupt status bit |

## Verification
The assertions rest on these assumptions about the inputs:
- All inputs are known (never X) from the first edge after reset.
- `cnt_init` holds its value while `clr_halt` is high.
- `sts_wr` and `clr_halt` may arrive together with a result in any cycle.

The stimulus meets these assumptions as follows:
- Every input is set to a defined value before reset is released.
- Inputs change only on the falling clock edge.
- Each strobe is held for exactly one cycle.

Collisions are created on purpose, so that the priority rules of R9 and R11 are exercised.

// File: rtl/xet_pkg.sv
package xet_pkg;

    localparam logic [2:0] RC_OK      = 3'd0;
    localparam logic [2:0] RC_CRC     = 3'd1;
    localparam logic [2:0] RC_TMO     = 3'd2;
    localparam logic [2:0] RC_BADPID  = 3'd3;
    localparam logic [2:0] RC_OVERRUN = 3'd4;
    localparam logic [2:0] RC_PROTO   = 3'd5;

    localparam logic [1:0] PK_OUT   = 2'd0;
    localparam logic [1:0] PK_IN    = 2'd1;
    localparam logic [1:0] PK_SETUP = 2'd2;

    localparam logic [1:0] HK_ACK   = 2'd0;
    localparam logic [1:0] HK_NAK   = 2'd1;
    localparam logic [1:0] HK_NYET  = 2'd2;
    localparam logic [1:0] HK_STALL = 2'd3;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_SUCCESS,
        EV_COUNTED,
        EV_BABBLE
    } ev_e;

    typedef enum logic [1:0] {
        ST_ACTIVE,
        ST_HALT_ERR,
        ST_HALT_BABBLE
    } st_e;

endpackage

// File: rtl/xet_classify.sv
module xet_classify
    import xet_pkg::*;
(
    input  logic       vld,
    input  logic [2:0] code,
    input  logic [1:0] pid,
    input  logic       hs_dev,
    input  logic [1:0] hsk,
    input  logic       csplit,
    output ev_e        ev
);

    logic setup_hs_bad;
    logic split_nak;
    logic reclass;

    // SETUP token to a high-speed device must never see NAK or NYET
    assign setup_hs_bad = (pid == PK_SETUP) && hs_dev &&
                          ((hsk == HK_NAK) || (hsk == HK_NYET));
    // low/full-speed complete-split answered with NAK
    assign split_nak    = !hs_dev && csplit && (hsk == HK_NAK);
    assign reclass      = setup_hs_bad || split_nak;

    always_comb begin
        ev = EV_NONE;
        if (vld) begin
            unique case (code)
                RC_CRC, RC_TMO, RC_BADPID, RC_PROTO: ev = EV_COUNTED;
                RC_OVERRUN:                          ev = EV_BABBLE;
                RC_OK:    ev = reclass ? EV_COUNTED : EV_SUCCESS;
                default:  ev = EV_SUCCESS;
            endcase
        end
    end

endmodule

// File: rtl/xet_retry_cnt.sv
module xet_retry_cnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         expire
);

    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    assign expire = dec && (cnt == ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= ZERO;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != ZERO)) begin
            cnt <= cnt - ONE;
        end
    end

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && cnt != ZERO) |=> (cnt == $past(cnt) - ONE)); // R1

    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == ZERO && !load) |=> (cnt == ZERO)); // R8

endmodule

// File: rtl/xet_irq_sts.sv
module xet_irq_sts (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic wr,
    input  logic wdata,
    output logic sts
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts <= 1'b0;
        end else if (set) begin
            sts <= 1'b1;
        end else if (wr && wdata) begin
            sts <= 1'b0;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> sts); // R11

    AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts && wr && !wdata) |=> sts); // R7

    AST_W1_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && wr && wdata) |=> !sts); // R7

endmodule

// File: rtl/xet_ctrl.sv
module xet_ctrl
    import xet_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ev_e  ev,
    input  logic clr_halt,
    input  logic expire,
    output logic cnt_dec,
    output logic irq_set,
    output logic halted,
    output logic xact_err,
    output logic babble
);

    st_e st, st_nx;
    logic active;

    assign active  = (st == ST_ACTIVE);
    assign halted  = !active;
    assign cnt_dec = active && !clr_halt && (ev == EV_COUNTED);
    assign irq_set = expire;

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_ACTIVE: begin
                if (clr_halt)                 st_nx = ST_ACTIVE;
                else if (ev == EV_BABBLE)     st_nx = ST_HALT_BABBLE;
                else if (expire)              st_nx = ST_HALT_ERR;
            end
            ST_HALT_ERR, ST_HALT_BABBLE: begin
                if (clr_halt)                 st_nx = ST_ACTIVE;
            end
            default:                          st_nx = ST_ACTIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_ACTIVE;
        else        st <= st_nx;
    end

    // flag outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xact_err <= 1'b0;
            babble   <= 1'b0;
        end else if (clr_halt) begin
            xact_err <= 1'b0;
            babble   <= 1'b0;
        end else if (active) begin
            if (ev == EV_COUNTED) xact_err <= 1'b1;
            if (ev == EV_BABBLE)  babble   <= 1'b1;
        end
    end

    AST_BABBLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && ev == EV_BABBLE && !clr_halt) |=> (st == ST_HALT_BABBLE && babble)); // R6

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !clr_halt) |=> ($stable(xact_err) && $stable(babble) && halted)); // R9

    AST_CLR_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_halt |=> (!halted && !xact_err && !babble)); // R9

endmodule

// File: rtl/xact_err_tracker.sv
module xact_err_tracker
    import xet_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_vld,
    input  logic [2:0]       res_code,
    input  logic [1:0]       pid_kind,
    input  logic             hs_dev,
    input  logic [1:0]       hshake,
    input  logic             csplit,
    input  logic             clr_halt,
    input  logic [CNT_W-1:0] cnt_init,
    input  logic             sts_wr,
    input  logic             sts_wdata,
    output logic [CNT_W-1:0] err_cnt,
    output logic             xact_err,
    output logic             babble,
    output logic             halted,
    output logic             err_irq
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    ev_e  ev;
    logic cnt_dec;
    logic expire;
    logic irq_set;

    xet_classify u_cls (
        .vld    (res_vld),
        .code   (res_code),
        .pid    (pid_kind),
        .hs_dev (hs_dev),
        .hsk    (hshake),
        .csplit (csplit),
        .ev     (ev)
    );

    xet_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .clr_halt (clr_halt),
        .expire   (expire),
        .cnt_dec  (cnt_dec),
        .irq_set  (irq_set),
        .halted   (halted),
        .xact_err (xact_err),
        .babble   (babble)
    );

    xet_retry_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (clr_halt),
        .load_val (cnt_init),
        .dec      (cnt_dec),
        .cnt      (err_cnt),
        .expire   (expire)
    );

    xet_irq_sts u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (irq_set),
        .wr    (sts_wr),
        .wdata (sts_wdata),
        .sts   (err_irq)
    );

    AST_IRQ_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_irq) |-> ($past(err_cnt) == CNT_ONE && err_cnt == '0 && halted)); // R2

endmodule

// File: tb/xact_err_tracker_test.sv
`timescale 1ns/1ps
module xact_err_tracker_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       res_vld = 1'b0;
    logic [2:0] res_code = 3'd0;
    logic [1:0] pid_kind = 2'd0;
    logic       hs_dev = 1'b0;
    logic [1:0] hshake = 2'd0;
    logic       csplit = 1'b0;
    logic       clr_halt = 1'b0;
    logic [1:0] cnt_init = 2'd0;
    logic       sts_wr = 1'b0;
    logic       sts_wdata = 1'b0;
    logic [1:0] err_cnt;
    logic       xact_err, babble, halted, err_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    xact_err_tracker uut (
        .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_code(res_code),
        .pid_kind(pid_kind), .hs_dev(hs_dev), .hshake(hshake), .csplit(csplit),
        .clr_halt(clr_halt), .cnt_init(cnt_init), .sts_wr(sts_wr),
        .sts_wdata(sts_wdata), .err_cnt(err_cnt), .xact_err(xact_err),
        .babble(babble), .halted(halted), .err_irq(err_irq)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(string req, int cnt, int xe, int bb, int hl, int irq);
        chk(req, "err_cnt", int'(err_cnt), cnt);
        chk(req, "xact_err", int'(xact_err), xe);
        chk(req, "babble", int'(babble), bb);
        chk(req, "halted", int'(halted), hl);
        chk(req, "err_irq", int'(err_irq), irq);
    endtask

    // one result cycle; outputs checked at the following falling edge
    task automatic result(logic [2:0] c, logic [1:0] p, logic h, logic [1:0] k, logic s);
        @(negedge clk);
        res_vld = 1'b1; res_code = c; pid_kind = p; hs_dev = h; hshake = k; csplit = s;
        @(negedge clk);
        res_vld = 1'b0;
    endtask

    task automatic reload(logic [1:0] v);
        @(negedge clk);
        clr_halt = 1'b1; cnt_init = v;
        @(negedge clk);
        clr_halt = 1'b0;
    endtask

    task automatic sts_write(logic d);
        @(negedge clk);
        sts_wr = 1'b1; sts_wdata = d;
        @(negedge clk);
        sts_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk_all("R12", 0, 0, 0, 0, 0);
    endtask

    task automatic t_countdown();
        reload(2'd3);
        chk_all("R9", 3, 0, 0, 0, 0);
        result(3'd0, 2'd1, 1'b1, 2'd0, 1'b0);
        chk_all("R10", 3, 0, 0, 0, 0);
        result(3'd1, 2'd1, 1'b1, 2'd0, 1'b0);
        chk_all("R1", 2, 1, 0, 0, 0);
        result(3'd0, 2'd0, 1'b1, 2'd0, 1'b0);
        chk_all("R10", 2, 1, 0, 0, 0);
        result(3'd7, 2'd0, 1'b1, 2'd0, 1'b0);
        chk("R10", "err_cnt after unused code", int'(err_cnt), 2);
        result(3'd2, 2'd1, 1'b1, 2'd0, 1'b0);
        chk_all("R2", 1, 1, 0, 0, 0);
        result(3'd3, 2'd1, 1'b1, 2'd0, 1'b0);
        chk_all("R2", 0, 1, 0, 1, 1);
        result(3'd4, 2'd1, 1'b1, 2'd0, 1'b0);
        chk_all("R9", 0, 1, 0, 1, 1);
    endtask

    task automatic t_ack();
        sts_write(1'b0);
        chk("R7", "err_irq after write 0", int'(err_irq), 1);
        sts_write(1'b1);
        chk("R7", "err_irq after write 1", int'(err_irq), 0);
        reload(2'd3);
        chk_all("R9", 3, 0, 0, 0, 0);
        result(3'd5, 2'd0, 1'b0, 2'd0, 1'b0);
        chk_all("R1", 2, 1, 0, 0, 0);
    endtask

    task automatic t_setup_reclass();
        reload(2'd3);
        result(3'd0, 2'd2, 1'b1, 2'd1, 1'b0);
        chk_all("R3", 2, 1, 0, 0, 0);
        reload(2'd3);
        result(3'd0, 2'd2, 1'b1, 2'd0, 1'b0);
        chk_all("R3", 3, 0, 0, 0, 0);
        result(3'd0, 2'd2, 1'b1, 2'd2, 1'b0);
        chk_all("R4", 2, 1, 0, 0, 0);
        result(3'd0, 2'd1, 1'b1, 2'd1, 1'b0);
        chk("R3", "IN NAK is success", int'(err_cnt), 2);
    endtask

    task automatic t_split();
        reload(2'd2);
        result(3'd0, 2'd1, 1'b0, 2'd1, 1'b1);
        chk_all("R5", 1, 1, 0, 0, 0);
        reload(2'd2);
        result(3'd0, 2'd1, 1'b0, 2'd1, 1'b0);
        chk_all("R5", 2, 0, 0, 0, 0);
    endtask

    task automatic t_set_wins();
        reload(2'd1);
        @(negedge clk);
        res_vld = 1'b1; res_code = 3'd1; sts_wr = 1'b1; sts_wdata = 1'b1;
        @(negedge clk);
        res_vld = 1'b0; sts_wr = 1'b0;
        chk_all("R11", 0, 1, 0, 1, 1);
        sts_write(1'b1);
        chk("R7", "err_irq cleared", int'(err_irq), 0);
    endtask

    task automatic t_babble();
        reload(2'd3);
        result(3'd4, 2'd1, 1'b1, 2'd0, 1'b0);
        chk_all("R6", 3, 0, 1, 1, 0);
        result(3'd1, 2'd1, 1'b1, 2'd0, 1'b0);
        chk_all("R9", 3, 0, 1, 1, 0);
    endtask

    task automatic t_zero();
        reload(2'd0);
        result(3'd1, 2'd1, 1'b1, 2'd0, 1'b0);
        chk_all("R8", 0, 1, 0, 0, 0);
        result(3'd2, 2'd1, 1'b1, 2'd0, 1'b0);
        chk_all("R8", 0, 1, 0, 0, 0);
    endtask

    task automatic t_clr_priority();
        @(negedge clk);
        clr_halt = 1'b1; cnt_init = 2'd3;
        res_vld = 1'b1; res_code = 3'd4;
        @(negedge clk);
        clr_halt = 1'b0; res_vld = 1'b0;
        chk_all("R9", 3, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_countdown();
        t_ack();
        t_setup_reclass();
        t_split();
        t_set_wins();
        t_babble();
        t_zero();
        t_clr_priority();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule